// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Scheduler

This block keeps an asynchronous 256K x 4 dynamic memory refreshed and brings it up after power-on. After reset it waits out a mandatory quiet period in which the strobes must stay inactive. It then hands a fixed number of warm-up refresh cycles to the strobe sequencer and raises `ready`. From that point on it issues one refresh credit per fixed interval. The interval is sized so that every row is visited well inside the retention window, even when up to `DEBT_MAX` credits are held back by access traffic.

The block acts as the arbiter in front of the strobe sequencer. Whenever the sequencer reports idle, the block grants either the pending normal access or one refresh, at most one grant per cycle. Normal accesses win while refresh credits are few. Once the credit count saturates, refresh wins. With `cbrSel` low, every refresh is a row-only strobe cycle, and the block supplies the row address from its own wrapping counter. With `cbrSel` high, the memory's internal counter chooses the row, and the block's row counter does not move. The strobe pins themselves are driven by the sequencer, not by this block.

Timing parameters are given in microseconds together with the clock rate in MHz:
- quiet period `PAUSE_CYC = CLK_MHZ*PAUSE_US`
- retention window `WINDOW_CYC = CLK_MHZ*WINDOW_US`
- refresh interval `INTERVAL_CYC = WINDOW_CYC/(2**ROW_BITS + DEBT_MAX + 2)`

Top module: `dram_ref_sched`

## Requirements
- R1: While `rstN` is low, `ready`, `accGnt`, `refGnt`, `refPending` and `refUrgent` are 0 and `refRow` is 0.
- R2: Counting the cycle in which reset is released as cycle 0, no grant of any kind appears in cycles 0 to PAUSE_CYC-1. With the sequencer idle, the first warm-up refresh grant appears in cycle PAUSE_CYC.
- R3: After the quiet period, exactly WARMUP refresh grants are issued, each in a cycle where `seqIdle` is 1. `ready` rises in the cycle after the last of them and then stays high. `accGnt` stays 0 while `ready` is 0.
- R4: `refMode` is 0 (row-only refresh using `refRow`) when `cbrSel` is 0, and 1 (strobe-order refresh using the memory's internal counter) when `cbrSel` is 1.
- R5: With `refMode` 0, `refRow` shows the row for the refresh granted in that cycle and advances by one after every refresh grant, wrapping from 2**ROW_BITS-1 to 0. With `refMode` 1, it holds its value.
- R6: Counting the first cycle with `ready` high as run cycle 0, one refresh credit is added at the end of every run cycle k with k mod INTERVAL_CYC = INTERVAL_CYC-1. With no access traffic and an idle sequencer, refresh grants fall exactly at run cycles INTERVAL_CYC, 2*INTERVAL_CYC, and so on.
- R7: The credit count goes down by one for each run-phase refresh grant and saturates at DEBT_MAX. `refPending` is 1 exactly when the count is above 0. `refUrgent` is 1 exactly when the count equals DEBT_MAX.
- R8: When `ready` and `seqIdle` are both 1, a refresh is granted if the count is DEBT_MAX. Otherwise an access is granted if `accReq` is 1. Otherwise a refresh is granted if the count is above 0.
- R9: No grant is issued when `seqIdle` is 0, and `accGnt` and `refGnt` are never high together.
- R10: Under continuous access traffic, every span of WINDOW_CYC consecutive run cycles contains at least 2**ROW_BITS refresh grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cbrSel | input | 1 | Refresh style select, held static outside reset: 0 row-only, 1 internal-counter |
| accReq | input | 1 | A normal read or write access is waiting |
| seqIdle | input | 1 | Strobe sequencer can accept a command this cycle |
| accGnt | output | 1 | Access granted this cycle |
| refGnt | output | 1 | Refresh granted this cycle |
| refMode | output | 1 | Refresh style for the granted refresh |
| refRow | output | ROW_BITS | Row address for a row-only refresh |
| refPending | output | 1 | At least one refresh credit outstanding |
| refUrgent | output | 1 | Credit count saturated; refresh outranks accesses |
| ready | output | 1 | Start-up sequence complete |

## Verification
The bench builds the block with `CLK_MHZ=1`, `PAUSE_US=30`, `WINDOW_US=600` and `ROW_BITS=4`, keeping `WARMUP=8` and `DEBT_MAX=8`. This gives a 30-cycle quiet period, a 600-cycle window and a 23-cycle interval for 16 rows. With these values the bench can step through the whole start-up sequence cycle by cycle. It can also see the row counter wrap several times, hold the credit count in saturation, and slide a full retention window over thousands of traffic cycles while checking grant priority against an arithmetic credit model every cycle.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WARM  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic countPause;
    logic runTimer;
    logic warmGrant;
    logic runGrant;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pauseDone;
    logic lastWarm;
    logic debtZero;
    logic debtFull;
  } status_t;

endpackage

// File: rtl/dram_ref_dp.sv
module dram_ref_dp
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC    = 10000,
  parameter int INTERVAL_CYC = 785,
  parameter int ROW_BITS     = 9,
  parameter int WARMUP       = 8,
  parameter int DEBT_MAX     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cbrSel,
  input  strobe_t             ctl,
  output status_t             stat,
  output logic [ROW_BITS-1:0] refRow
);

  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INTERVAL_CYC + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam int WW = $clog2(WARMUP + 1);

  logic [PW-1:0] pauseCnt;
  logic [IW-1:0] intCnt;
  logic [DW-1:0] debt;
  logic [WW-1:0] warmCnt;
  logic          tick;

  // quiet-period countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                pauseCnt <= PW'(PAUSE_CYC - 1);
    else if (ctl.countPause && pauseCnt != '0) pauseCnt <= pauseCnt - 1'b1;
  end

  // refresh interval timer
  assign tick = ctl.runTimer && (intCnt == IW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              intCnt <= '0;
    else if (!ctl.runTimer) intCnt <= '0;
    else if (tick)          intCnt <= '0;
    else                    intCnt <= intCnt + 1'b1;
  end

  // saturating refresh credit count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) debt <= '0;
    else begin
      unique case ({tick, ctl.runGrant})
        2'b10:   if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  // warm-up cycle count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (ctl.warmGrant) warmCnt <= warmCnt + 1'b1;
  end

  // row counter for row-only refresh
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refRow <= '0;
    else if ((ctl.warmGrant || ctl.runGrant) && !cbrSel) refRow <= refRow + 1'b1;
  end

  assign stat.pauseDone = (pauseCnt == '0);
  assign stat.lastWarm  = (warmCnt == WW'(WARMUP - 1));
  assign stat.debtZero  = (debt == '0);
  assign stat.debtFull  = (debt == DW'(DEBT_MAX));

endmodule

// File: rtl/dram_ref_ctrl.sv
module dram_ref_ctrl
  import dram_ref_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cbrSel,
  input  logic    accReq,
  input  logic    seqIdle,
  input  status_t stat,
  output strobe_t ctl,
  output logic    accGnt,
  output logic    refGnt,
  output logic    refMode,
  output logic    refPending,
  output logic    refUrgent,
  output logic    ready
);

  phase_t phase, phaseNext;
  logic   warmGnt, runRef;

  assign ready   = (phase == PH_RUN);
  assign warmGnt = (phase == PH_WARM) && seqIdle;
  assign runRef  = ready && seqIdle &&
                   (stat.debtFull || (!accReq && !stat.debtZero));
  assign accGnt  = ready && seqIdle && accReq && !stat.debtFull;
  assign refGnt  = warmGnt || runRef;

  assign refPending = ready && !stat.debtZero;
  assign refUrgent  = ready && stat.debtFull;
  assign refMode    = cbrSel;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_PAUSE: if (stat.pauseDone)           phaseNext = PH_WARM;
      PH_WARM:  if (warmGnt && stat.lastWarm) phaseNext = PH_RUN;
      default:  phaseNext = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_PAUSE;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctl.countPause = (phase == PH_PAUSE);
    ctl.runTimer   = ready;
    ctl.warmGrant  = warmGnt;
    ctl.runGrant   = runRef;
  end

endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int PAUSE_US  = 200,
  parameter int WINDOW_US = 8200,
  parameter int ROW_BITS  = 9,
  parameter int WARMUP    = 8,
  parameter int DEBT_MAX  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cbrSel,
  input  logic                accReq,
  input  logic                seqIdle,
  output logic                accGnt,
  output logic                refGnt,
  output logic                refMode,
  output logic [ROW_BITS-1:0] refRow,
  output logic                refPending,
  output logic                refUrgent,
  output logic                ready
);

  localparam int PAUSE_CYC    = CLK_MHZ * PAUSE_US;
  localparam int WINDOW_CYC   = CLK_MHZ * WINDOW_US;
  localparam int ROWS         = 1 << ROW_BITS;
  localparam int INTERVAL_CYC = WINDOW_CYC / (ROWS + DEBT_MAX + 2);

  strobe_t ctl;
  status_t stat;

  dram_ref_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cbrSel    (cbrSel),
    .accReq    (accReq),
    .seqIdle   (seqIdle),
    .stat      (stat),
    .ctl       (ctl),
    .accGnt    (accGnt),
    .refGnt    (refGnt),
    .refMode   (refMode),
    .refPending(refPending),
    .refUrgent (refUrgent),
    .ready     (ready)
  );

  dram_ref_dp #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INTERVAL_CYC(INTERVAL_CYC),
    .ROW_BITS    (ROW_BITS),
    .WARMUP      (WARMUP),
    .DEBT_MAX    (DEBT_MAX)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .cbrSel(cbrSel),
    .ctl   (ctl),
    .stat  (stat),
    .refRow(refRow)
  );

endmodule

// File: rtl/dram_ref_sched_chk.sv
module dram_ref_sched_chk #(
  parameter int ROW_BITS = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic                seqIdle,
  input logic                accGnt,
  input logic                refGnt,
  input logic                refMode,
  input logic [ROW_BITS-1:0] refRow,
  input logic                refUrgent,
  input logic                ready
);

  AST_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !accGnt);  // R3

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);  // R3

  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (refGnt && !refMode) |=> refRow == ROW_BITS'($past(refRow) + 1'b1));  // R5

  AST_URGENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (refUrgent && seqIdle) |-> (refGnt && !accGnt));  // R8

  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !seqIdle |-> !(accGnt || refGnt));  // R9

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !(accGnt && refGnt));  // R9

endmodule

bind dram_ref_sched dram_ref_sched_chk #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .seqIdle  (seqIdle),
  .accGnt   (accGnt),
  .refGnt   (refGnt),
  .refMode  (refMode),
  .refRow   (refRow),
  .refUrgent(refUrgent),
  .ready    (ready)
);

// File: tb/dram_ref_sched_bench.sv
module dram_ref_sched_bench;

  localparam int RB   = 4;
  localparam int NROW = 1 << RB;
  localparam int BP   = 30;
  localparam int BW   = 600;
  localparam int WU   = 8;
  localparam int DM   = 8;
  localparam int BI   = BW / (NROW + DM + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cbrSel = 1'b0;
  logic accReq = 1'b0;
  logic seqIdle = 1'b0;
  logic accGnt, refGnt, refMode, refPending, refUrgent, ready;
  logic [RB-1:0] refRow;

  always #10 clk = ~clk;

  dram_ref_sched #(
    .CLK_MHZ(1), .PAUSE_US(BP), .WINDOW_US(BW),
    .ROW_BITS(RB), .WARMUP(WU), .DEBT_MAX(DM)
  ) u_dram_ref_sched (
    .clk(clk), .rstN(rstN), .cbrSel(cbrSel), .accReq(accReq), .seqIdle(seqIdle),
    .accGnt(accGnt), .refGnt(refGnt), .refMode(refMode), .refRow(refRow),
    .refPending(refPending), .refUrgent(refUrgent), .ready(ready)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // sampled outputs and models
  logic sAcc, sRef, sReady, sPend, sUrg, sMode;
  logic [RB-1:0] sRow;
  int rowM, debtM, runCyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample();
    sAcc = accGnt; sRef = refGnt; sReady = ready; sPend = refPending;
    sUrg = refUrgent; sMode = refMode; sRow = refRow;
  endtask

  // one clock: update models for the edge, drive, sample, check per-cycle rules
  task automatic step(input logic aR, input logic sI);
    bit tk;
    bit expRef, expAcc;
    @(posedge clk);
    if (sReady) begin
      tk = ((runCyc % BI) == BI - 1);
      if (tk && !sRef && debtM < DM) debtM++;
      else if (!tk && sRef) debtM--;
      runCyc++;
    end
    if (sRef && !cbrSel) rowM = (rowM + 1) % NROW;
    #4 accReq = aR; seqIdle = sI;
    #4 sample();
    chk(!(sRef && sAcc), "R9 both grants", int'(sRef) + int'(sAcc), 1);
    if (!sI) chk(!(sRef || sAcc), "R9 grant while busy", int'(sRef || sAcc), 0);
    if (!sReady) chk(!sAcc, "R3 access before ready", int'(sAcc), 0);
    if (sReady) begin
      expRef = sI && (debtM == DM || (!aR && debtM > 0));
      expAcc = sI && aR && debtM != DM;
      chk(sRef == expRef, "R8 refresh grant", int'(sRef), int'(expRef));
      chk(sAcc == expAcc, "R8 access grant", int'(sAcc), int'(expAcc));
      chk(sPend == (debtM > 0), "R7 pending", int'(sPend), int'(debtM > 0));
      chk(sUrg == (debtM == DM), "R7 urgent", int'(sUrg), int'(debtM == DM));
    end
    if (sRef) begin
      chk(int'(sRow) == rowM, "R5 row", int'(sRow), rowM);
      chk(sMode == cbrSel, "R4 mode", int'(sMode), int'(cbrSel));
    end
  endtask

  // reset, quiet period and warm-up; alt toggles the sequencer idle flag
  task automatic bootRun(input logic cbr, input bit alt);
    int firstG, lastG, nGrant, readyAt, fe, le;
    @(posedge clk); #4 rstN = 1'b0; cbrSel = cbr; accReq = 1'b1; seqIdle = 1'b1;
    repeat (3) @(posedge clk);
    #8 sample();
    chk(!sReady && !sAcc && !sRef && !sPend && !sUrg, "R1 reset outputs",
        int'({sReady, sAcc, sRef, sPend, sUrg}), 0);
    chk(sRow == '0, "R1 reset row", int'(sRow), 0);
    rowM = 0; debtM = 0; runCyc = 0;
    @(posedge clk); #4 rstN = 1'b1;
    #4 sample();
    chk(!sRef && !sAcc, "R2 grant in release cycle", int'(sRef || sAcc), 0);
    firstG = -1; lastG = -1; nGrant = 0; readyAt = -1;
    for (int n = 1; n < BP + 3 * WU + 10 && readyAt < 0; n++) begin
      step(1'b1, alt ? logic'(n % 2 == 0) : 1'b1);
      if (sReady) readyAt = n;
      else if (sRef) begin
        if (firstG < 0) firstG = n;
        lastG = n;
        nGrant++;
      end
    end
    fe = alt ? BP + (BP % 2) : BP;
    le = fe + (alt ? 2 : 1) * (WU - 1);
    chk(firstG == fe, "R2 first warm-up grant cycle", firstG, fe);
    chk(nGrant == WU, "R3 warm-up grant count", nGrant, WU);
    chk(lastG == le, "R3 last warm-up grant cycle", lastG, le);
    chk(readyAt == le + 1, "R3 ready cycle", readyAt, le + 1);
  endtask

  initial begin
    int prevG, nG, drain, busy, winCnt, minWin, nAcc, idx;
    bit hist[BW];

    // run 1: row-only mode, sequencer always idle during start-up
    bootRun(1'b0, 1'b0);

    // idle refresh cadence with row wrap
    prevG = 0; nG = 0;
    for (int k = 0; k < 20 * BI + 1; k++) begin
      step(1'b0, 1'b1);
      if (sRef) begin
        chk(runCyc - prevG == BI, "R6 refresh spacing", runCyc - prevG, BI);
        prevG = runCyc; nG++;
      end
    end
    chk(nG == 20, "R6 refresh count", nG, 20);
    chk(int'(sRow) == (WU + 20) % NROW, "R5 row after wrap", int'(sRow), (WU + 20) % NROW);

    // saturation with a busy sequencer
    for (int k = 0; k < (DM + 3) * BI; k++) step(1'b0, 1'b0);
    chk(sUrg && sPend, "R7 saturated flags", int'({sUrg, sPend}), 3);
    step(1'b1, 1'b1);
    chk(sRef && !sAcc, "R8 urgent refresh wins", int'(sRef), 1);
    step(1'b1, 1'b1);
    chk(sAcc && !sRef, "R8 access wins below limit", int'(sAcc), 1);
    drain = 0;
    for (int k = 0; k < 3 * DM && sPend; k++) begin
      step(1'b0, 1'b1);
      if (sRef) drain++;
    end
    chk(!sPend, "R7 debt drained", int'(sPend), 0);
    chk(drain >= DM - 1, "R7 drain length", drain, DM - 1);

    // continuous traffic, sequencer busy two cycles after each grant
    busy = 0; winCnt = 0; minWin = 1 << 30; nAcc = 0;
    for (int i = 0; i < BW; i++) hist[i] = 1'b0;
    for (int k = 0; k < 4 * BW; k++) begin
      step(1'b1, logic'(busy == 0));
      if (sRef || sAcc) busy = 2; else if (busy > 0) busy--;
      if (sAcc) nAcc++;
      idx = k % BW;
      winCnt = winCnt - int'(hist[idx]) + int'(sRef);
      hist[idx] = sRef;
      if (k >= BW - 1 && winCnt < minWin) minWin = winCnt;
    end
    chk(minWin >= NROW, "R10 refreshes per window", minWin, NROW);
    chk(nAcc > 2 * BW / 3 - BW / 4, "R8 traffic served", nAcc, 2 * BW / 3 - BW / 4);

    // run 2: internal-counter mode, sequencer idle every other cycle
    bootRun(1'b1, 1'b1);
    nG = 0;
    for (int k = 0; k < 3 * BI + 2; k++) begin
      step(1'b0, 1'b1);
      if (sRef) nG++;
    end
    chk(nG == 3, "R6 refresh count internal mode", nG, 3);
    chk(sRow == '0 && sMode, "R5 row held in internal mode", int'(sRow), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule